// File: doc/BRIEF.md
# Single-Byte SPI Master Without Buffering

This block is a serial peripheral interface master that moves one 8-bit byte per start command. It has one transmit holding register and one receive holding register, and no queue. Software programs the clock phase, clock polarity, bit order and an optional internal loopback through a small byte-wide register bus. It loads the transmit byte, then writes the start bit. When the byte has been shifted, the block raises an interrupt. Software reads the received byte, which clears the interrupt, and refills the transmit register for the next byte.

The serial clock runs at the bus clock divided by 4×(divisor+1), where the divisor is an 8-bit register. Chip selects are generated outside the block. The busy flag stays set for one bus cycle after the last serial clock edge, so software that sees the interrupt may still find the port busy for that one cycle.

Top module: `byte_spi_master`

## Requirements
- R1: Registers sit at these byte offsets: 0 = mode (bits 4..0 readable, upper bits read 0), 1 = receive data, 2 = transmit data (read back), 3 = control (write only, reads 0), 4 = status, 6 = clock divisor (read back). Offsets 5 and 7 read 0.
- R2: A write to offset 3 with bit 0 set starts a transfer of the current transmit byte when the port is enabled and idle. Status bit 1 (busy) reads 1 while the transfer runs.
- R3: While a transfer runs, SCK gives 8 pulses, each 4×(divisor+1) bus cycles long. Whenever no transfer runs, SCK sits at the idle level given by mode bit 1 (1 = high).
- R4: Mode bit 4 selects the phase. When it is 1, the master samples MISO on the leading SCK edge and changes MOSI on the trailing edge, with the first bit valid before the first edge. When it is 0, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Mode bit 2 set sends and receives the least significant bit first. Clear, the most significant bit goes first.
- R6: With mode bit 0 set, the received byte equals the transmitted byte and the MISO pin is ignored.
- R7: At the last SCK edge, status bit 0 (receive ready) and irq_o are set and the received byte is readable at offset 1. Busy clears one bus cycle later, so busy reads 1 for exactly 32×(divisor+1)+1 cycles after the start write.
- R8: Reading offset 1 with rd_i clears receive ready and drops irq_o.
- R9: A start command written while busy is ignored: the running byte neither restarts nor lengthens.
- R10: With mode bit 3 (enable) clear, SCK stays at its idle level, MOSI is held low, and start commands are ignored.
- R11: After reset every register reads 0, irq_o is low, SCK is low and MOSI is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (side effect on receive register) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Byte-complete interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A bench slave captures MOSI and drives MISO on the edges each phase setting prescribes. A wrong phase, bit order or edge choice therefore shows up as a corrupted byte at one end or the other. Random transfers mix all four clock modes, both bit orders, loopback and small divisors. In loopback, MISO carries the complement of the byte, so a design that does not ignore the pin fails. Directed cases cover divisors 0 and 255, single-bit patterns that reveal bit-order swaps, a restart issued mid-byte (measured by the busy length), and a disabled port.

// File: rtl/byte_spi_pkg.sv
package byte_spi_pkg;
  localparam int unsigned OFF_MODE = 0;
  localparam int unsigned OFF_RX   = 1;
  localparam int unsigned OFF_TX   = 2;
  localparam int unsigned OFF_CTRL = 3;
  localparam int unsigned OFF_STAT = 4;
  localparam int unsigned OFF_DIV  = 6;

  // field order fixes the register bit positions 4..0
  typedef struct packed {
    logic scp;
    logic en;
    logic lsb;
    logic ci;
    logic loop;
  } mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} sh_state_e;
endpackage

// File: rtl/spi_csr.sv
module spi_csr
  import byte_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              start_o,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] tx_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              rbr_o
);
  localparam int unsigned MODE_W = $bits(mode_t);

  mode_t             mode_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic [DIV_W-1:0]  div_q;
  logic              rbr_q;
  logic              wr_mode, wr_tx, wr_div, rd_rx;

  assign wr_mode = wr_i && (addr_i == ADDR_W'(OFF_MODE));
  assign wr_tx   = wr_i && (addr_i == ADDR_W'(OFF_TX));
  assign wr_div  = wr_i && (addr_i == ADDR_W'(OFF_DIV));
  assign rd_rx   = rd_i && (addr_i == ADDR_W'(OFF_RX));
  assign start_o = wr_i && (addr_i == ADDR_W'(OFF_CTRL)) && wdata_i[0]
                   && mode_q.en && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      div_q  <= '0;
      rbr_q  <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
      if (wr_tx)   tx_q   <= wdata_i;
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
      if (done_i) begin
        rx_q  <= rx_i;
        rbr_q <= 1'b1;
      end else if (rd_rx) begin
        rbr_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFF_MODE): rdata_o = DATA_W'(mode_q);
      ADDR_W'(OFF_RX):   rdata_o = rx_q;
      ADDR_W'(OFF_TX):   rdata_o = tx_q;
      ADDR_W'(OFF_STAT): rdata_o = DATA_W'({busy_i, rbr_q});
      ADDR_W'(OFF_DIV):  rdata_o = DATA_W'(div_q);
      default:           rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign tx_o   = tx_q;
  assign div_o  = div_q;
  assign rbr_o  = rbr_q;
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  // half SCK period = 2*(div+1) bus cycles
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term   = {div_i, 1'b1};
  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import byte_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              loop_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              ph_o,
  output logic              dout_o
);
  localparam int unsigned EDGES = 2 * DATA_W;
  localparam int unsigned CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

  sh_state_e         state_q;
  logic [CNT_W-1:0]  edge_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt;
  logic              ph_q;
  logic              lead, last, smp_evt, out_evt, sin;

  assign lead    = ~edge_q[0];
  assign last    = (edge_q == LAST);
  assign smp_evt = tick_i && (cpha_i ? !lead : lead);
  assign out_evt = tick_i && (cpha_i ? (lead && edge_q != '0) : (!lead && !last));
  assign dout_o  = lsb_i ? tx_sh[0] : tx_sh[DATA_W-1];
  assign sin     = loop_i ? dout_o : miso_i;

  always_comb begin
    rx_nxt = rx_sh;
    if (smp_evt) rx_nxt = lsb_i ? {sin, rx_sh[DATA_W-1:1]} : {rx_sh[DATA_W-2:0], sin};
  end

  assign run_o  = (state_q == ST_SHIFT);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = run_o && tick_i && last;
  assign rx_o   = rx_nxt;
  assign ph_o   = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      ph_q    <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tx_sh   <= tx_i;
          rx_sh   <= '0;
          edge_q  <= '0;
          ph_q    <= 1'b0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick_i) begin
          ph_q   <= ~ph_q;
          edge_q <= edge_q + 1'b1;
          rx_sh  <= rx_nxt;
          if (out_evt) tx_sh <= lsb_i ? (tx_sh >> 1) : (tx_sh << 1);
          if (last) state_q <= ST_TAIL;
        end
        ST_TAIL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_spi_master.sv
module byte_spi_master
  import byte_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  mode_t             mode;
  logic [DATA_W-1:0] tx, rx;
  logic [DIV_W-1:0]  div;
  logic              start, busy, done, run, tick, ph, dout, rbr;
  logic              en, ci;

  assign en = mode.en;
  assign ci = mode.ci;

  spi_csr #(.DATA_W(DATA_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_csr (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_i(rx),
    .start_o(start), .mode_o(mode), .tx_o(tx), .div_o(div), .rbr_o(rbr)
  );

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .div_i(div), .tick_o(tick)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk_i, .rst_ni, .en_i(en), .start_i(start), .cpha_i(~mode.scp),
    .lsb_i(mode.lsb), .loop_i(mode.loop), .tick_i(tick), .tx_i(tx),
    .miso_i, .run_o(run), .busy_o(busy), .done_o(done), .rx_o(rx),
    .ph_o(ph), .dout_o(dout)
  );

  assign irq_o  = rbr;
  assign sck_o  = ci ^ ph;
  assign mosi_o = en && busy && dout;
endmodule

// File: rtl/byte_spi_master_chk.sv
module byte_spi_master_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              ci,
  input logic              busy,
  input logic              done,
  input logic              irq_o,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i
);
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> sck_o == ci); // R3
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !mosi_o && !busy); // R10
  AST_DONE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> irq_o && busy); // R7
  AST_BUSY_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |=> !busy); // R7
  AST_RX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(1) && !done) |=> !irq_o); // R8
endmodule

bind byte_spi_master byte_spi_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .en, .ci, .busy, .done, .irq_o, .sck_o, .mosi_o, .rd_i, .addr_i
);

// File: tb/byte_spi_master_tb_top.sv
module byte_spi_master_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, mosi_o;
  logic       miso_i = 1'b0;

  int checks = 0, errors = 0, cyc = 0;

  byte_spi_master dut_i (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // slave model state
  logic m_scp = 1'b0, m_ci = 1'b0, m_lsb = 1'b0;
  int   m_div = 0, bit_idx = 0, last_lead = -1, lead_cnt = 0;
  logic per_bad = 1'b0;
  logic [7:0] slv_tx = '0, slv_rx = '0;
  logic sck_prev = 1'b0;

  function automatic int pos(input logic lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  always @(negedge clk_i) begin
    if (sck_o !== sck_prev) begin
      logic lead;
      lead = (sck_o != m_ci);
      if (lead) begin
        if (last_lead >= 0 && (cyc - last_lead) != 4 * (m_div + 1)) per_bad = 1'b1;
        last_lead = cyc;
        lead_cnt++;
      end
      if (lead == m_scp && bit_idx < 8) begin
        slv_rx[pos(m_lsb, bit_idx)] = mosi_o;
        bit_idx++;
        if (bit_idx < 8) miso_i = slv_tx[pos(m_lsb, bit_idx)];
      end
    end
    sck_prev = sck_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk_i);
    addr_i = 3'(a); wdata_i = 8'(d); wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = 3'(a); rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // poll status after start write; returns busy length and irq/busy overlap
  task automatic wait_idle(output int blen, output logic irq_bsy);
    logic seen = 1'b0;
    blen = 0; irq_bsy = 1'b0;
    addr_i = 3'd4;
    for (int n = 0; n < 20000; n++) begin
      #1;
      if (rdata_o[0] && !seen) begin seen = 1'b1; irq_bsy = rdata_o[1]; end
      if (!rdata_o[1]) break;
      blen++;
      @(negedge clk_i);
    end
  endtask

  task automatic xfer(input logic scp, input logic lsb, input logic ci, input logic lp,
                      input int div, input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] d, exp_rx;
    int blen;
    logic irq_bsy;
    m_scp = scp; m_ci = ci; m_lsb = lsb; m_div = div;
    bus_wr(0, {3'b0, scp, 1'b1, lsb, ci, lp});
    bus_wr(6, div);
    bus_wr(2, tx);
    @(negedge clk_i);
    slv_tx = lp ? ~tx : stx; slv_rx = '0; bit_idx = 0;
    last_lead = -1; lead_cnt = 0; per_bad = 1'b0;
    miso_i = slv_tx[pos(lsb, 0)];
    bus_wr(3, 1);
    wait_idle(blen, irq_bsy);
    exp_rx = lp ? tx : stx;
    chk("R7 busy length", blen, 32 * (div + 1) + 1);
    chk("R7 busy at irq", irq_bsy, 1);
    chk("R3 sck pulses", lead_cnt, 8);
    chk("R3 sck period", per_bad, 0);
    chk("R3 sck idle", sck_o, ci);
    chk("R7 irq set", irq_o, 1);
    if (!lp) chk("R4 R5 slave got mosi", slv_rx, tx);
    bus_rd(1, d);
    chk(lp ? "R6 loopback rx" : "R4 R5 rx byte", d, exp_rx);
    #1 chk("R8 irq cleared", irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int blen, c0;
    logic irq_bsy;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R11 reset state, R1 reads
    chk("R11 irq", irq_o, 0);
    chk("R11 sck", sck_o, 0);
    chk("R11 mosi", mosi_o, 0);
    for (int a = 0; a < 8; a++) begin
      bus_rd(a, d);
      chk("R11 reg zero", d, 0);
    end
    // R1 readback and masking
    bus_wr(0, 8'hFF); bus_rd(0, d); chk("R1 mode mask", d, 8'h1F);
    bus_wr(0, 8'h00);
    bus_wr(6, 8'hA5); bus_rd(6, d); chk("R1 div readback", d, 8'hA5);
    bus_wr(2, 8'h3C); bus_rd(2, d); chk("R1 tx readback", d, 8'h3C);
    bus_wr(3, 8'h00); bus_rd(3, d); chk("R1 ctrl reads zero", d, 0);
    bus_rd(5, d); chk("R1 reserved zero", d, 0);
    // R10 disabled port
    bus_wr(0, 8'h02);
    bus_wr(3, 1);
    repeat (10) @(negedge clk_i);
    bus_rd(4, d);
    chk("R10 start ignored", d, 0);
    chk("R10 sck idle high", sck_o, 1);
    chk("R10 mosi low", mosi_o, 0);
    // directed corners
    xfer(1, 0, 0, 0, 0, 8'h80, 8'h01);   // R5 msb first
    xfer(1, 1, 0, 0, 0, 8'h80, 8'h01);   // R5 lsb first
    xfer(0, 0, 1, 0, 1, 8'hA5, 8'h5A);   // R4 trailing sample
    xfer(1, 0, 1, 1, 0, 8'hC3, 8'h00);   // R6 loopback
    xfer(0, 1, 0, 0, 255, 8'h96, 8'h69); // R3 largest divisor
    // R2 busy flag and R9 restart ignored
    bus_wr(0, 8'h19); bus_wr(6, 1); bus_wr(2, 8'h5B);
    bus_wr(3, 1);
    c0 = cyc;
    bus_rd(4, d); chk("R2 busy set", d[1], 1);
    repeat (20) @(negedge clk_i);
    bus_wr(2, 8'h00);
    bus_wr(3, 1);
    addr_i = 3'd4;
    for (int n = 0; n < 1000; n++) begin
      #1 if (!rdata_o[1]) break;
      @(negedge clk_i);
    end
    chk("R9 busy not extended", cyc - c0, 32 * 2 + 1);
    bus_rd(1, d); chk("R9 byte kept", d, 8'h5B);
    // random
    for (int k = 0; k < 30; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      xfer(r[0], r[1], r[2], r[3], int'($urandom % 4), 8'($urandom), 8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule